// File: doc/BRIEF.md
# Keyboard Code Latch and Key-Status Port

This block sits between a keyboard matrix scanner and the 8-bit data bus of a small microcomputer. Each time the scanner reports a new ordinary keypress, the block holds the key code and raises a "key waiting" strobe. Software polls one bus location to get the code with the strobe in the top bit. It touches a second location to acknowledge the key. That access drops the strobe, and a read there also reports whether any ordinary key is still held.

The scanner also presents a bitmap of every key that is currently held. Six positions in that bitmap are modifier or system keys: Reset, Control, Shift, Caps Lock and the two command keys on either side of the space bar. These never count as "a key is down" and never load the latch. The two command keys drive game switch inputs 0 and 1. Shift drives game switch 2 only when the board jumper input is set. Reset held together with Control raises a system reset request. Each switch can also be read by software as bit 7 of its own location.

Top module: `kbd_strobe_port`

## Requirements
- R1: After reset the strobe, the latched code, all three game switch outputs and the system reset request are 0, so a read of the key location returns 8'h00.
- R2: A key event whose index is not a modifier position loads its 7-bit code and sets the strobe at the next clock edge. This also happens when the previous strobe was never cleared, and the new code replaces the old one.
- R3: A read at the key location (default 16'hC000) returns the strobe in bit 7 and the latched code in bits 6:0, in the same cycle as the access, and leaves the strobe unchanged.
- R4: Any bus access, read or write, at the acknowledge location (default 16'hC010) clears the strobe at the next clock edge and keeps the latched code.
- R5: A read at the acknowledge location returns in bit 7 a 1 exactly when some held-key bitmap position outside the modifier positions is 1. Bits 6:0 are 0. The default modifier positions are Reset 63, Control 62, Shift 61, Caps Lock 60, open command key 59 and solid command key 58.
- R6: A key event whose index is a modifier position changes neither the latched code nor the strobe.
- R7: When an accepted key event and an acknowledge access fall in the same cycle, the strobe is set after that edge and holds the new code.
- R8: Game switch 0 follows the open command key and game switch 1 follows the solid command key, one clock after the bitmap changes. Each reads back as bit 7 (1 = pressed) at locations SW_BASE+0 and SW_BASE+1 (default 16'hC061, 16'hC062).
- R9: Game switch 2, read at SW_BASE+2, follows Shift only while the jumper input is 1. It is 0 otherwise.
- R10: The system reset request is 1 one clock after Reset and Control are both held. Reset alone or Control alone keeps it 0.
- R11: A read at any other location, or any cycle without bus_sel, returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_evt | input | 1 | One-cycle pulse: the scanner found a new keypress |
| key_idx | input | 6 | Bitmap position of the new key |
| key_code | input | 7 | Translated code of the new key |
| key_map | input | 64 | Held-key bitmap, 1 = held |
| shift_jmp | input | 1 | Jumper: route Shift to game switch 2 |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Bus address |
| rd_data | output | 8 | Read data, combinational from address |
| game_sw | output | 3 | Game switch inputs 0..2 |
| sys_rst_req | output | 1 | System reset request |

## Verification
A wrong strobe state appears at the key location within one read: a strobe that stays set after an acknowledge, or one that a modifier press sets, changes bit 7 on the next poll. A corrupted code appears the same way in bits 6:0. Errors in the modifier routing and the reset combination appear at game_sw or sys_rst_req one clock after the bitmap changes. The bench therefore drives each stimulus and checks the ports in the next cycle, and it also covers the edge collision, writes to the acknowledge location and jumper-off cases.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
   typedef enum logic [2:0] {
      RSEL_NONE,
      RSEL_KEY,
      RSEL_ANY,
      RSEL_SW0,
      RSEL_SW1,
      RSEL_SW2
   } rd_sel_e;

   localparam int NUM_GSW = 3;
endpackage

// File: rtl/kbd_latch.sv
module kbd_latch #(
   parameter int CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] code_in,
   input  logic              clr,
   output logic [CODE_W-1:0] code_q,
   output logic              strobe_q
);
   if (CODE_W < 1) begin : g_chk_w
      $error("kbd_latch: CODE_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q   <= '0;
         strobe_q <= 1'b0;
      end else if (load) begin
         code_q   <= code_in;
         strobe_q <= 1'b1;
      end else if (clr) begin
         strobe_q <= 1'b0;
      end
   end

   // R2, R7: an accepted event wins and carries its code
   a_r2_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (strobe_q && code_q == $past(code_in)));
   // R4: acknowledge without event drops the strobe
   a_r4_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !load) |=> !strobe_q);
   // R6: no accepted event, no code change
   a_r6_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(code_q));
endmodule

// File: rtl/kbd_mod_route.sv
module kbd_mod_route #(
   parameter int          NKEYS     = 64,
   parameter int          RST_IDX   = 63,
   parameter int          CTRL_IDX  = 62,
   parameter int          SHIFT_IDX = 61,
   parameter int          OPEN_IDX  = 59,
   parameter int          SOLID_IDX = 58,
   parameter logic [NKEYS-1:0] MOD_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NKEYS-1:0] key_map,
   input  logic             shift_jmp,
   output logic             any_down,
   output logic [kbd_pkg::NUM_GSW-1:0] gsw,
   output logic             rst_req
);
   import kbd_pkg::*;

   localparam int SRC_IDX [NUM_GSW] = '{OPEN_IDX, SOLID_IDX, SHIFT_IDX};

   logic [NUM_GSW-1:0] gsw_d;

   assign any_down = |(key_map & ~MOD_MASK);

   for (genvar g = 0; g < NUM_GSW; g++) begin : g_sw
      if (SRC_IDX[g] >= NKEYS) begin : g_chk
         $error("kbd_mod_route: switch source index out of range");
      end
      if (g == NUM_GSW - 1) begin : g_jmp
         assign gsw_d[g] = key_map[SRC_IDX[g]] & shift_jmp;
      end else begin : g_dir
         assign gsw_d[g] = key_map[SRC_IDX[g]];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gsw     <= '0;
         rst_req <= 1'b0;
      end else begin
         gsw     <= gsw_d;
         rst_req <= key_map[RST_IDX] & key_map[CTRL_IDX];
      end
   end

   // R10: a reset request needs both keys one cycle earlier
   a_r10_combo: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(key_map[CTRL_IDX] && key_map[RST_IDX]));
   // R9: jumper off keeps switch 2 low
   a_r9_jumper_off: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_jmp |=> !gsw[2]);
   // R8: command keys reach their switches
   a_r8_open_sw: assert property (@(posedge clk) disable iff (!rst_n)
      key_map[OPEN_IDX] |=> gsw[0]);
endmodule

// File: rtl/kbd_rd_mux.sv
module kbd_rd_mux #(
   parameter int                ADDR_W   = 16,
   parameter int                CODE_W   = 7,
   parameter logic [ADDR_W-1:0] KEY_ADDR = 16'hC000,
   parameter logic [ADDR_W-1:0] CLR_ADDR = 16'hC010,
   parameter logic [ADDR_W-1:0] SW_BASE  = 16'hC061
) (
   input  logic              bus_sel,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CODE_W-1:0] code_q,
   input  logic              strobe_q,
   input  logic              any_down,
   input  logic [kbd_pkg::NUM_GSW-1:0] gsw,
   output logic [CODE_W:0]   rd_data,
   output logic              clr_hit
);
   import kbd_pkg::*;

   logic [NUM_GSW-1:0] sw_hit;
   rd_sel_e            sel;

   for (genvar g = 0; g < NUM_GSW; g++) begin : g_swdec
      assign sw_hit[g] = (bus_addr == SW_BASE + ADDR_W'(g));
   end

   assign clr_hit = bus_sel && (bus_addr == CLR_ADDR);

   always_comb begin
      sel = RSEL_NONE;
      if (bus_sel && bus_rd) begin
         if (bus_addr == KEY_ADDR)      sel = RSEL_KEY;
         else if (bus_addr == CLR_ADDR) sel = RSEL_ANY;
         else if (sw_hit[0])            sel = RSEL_SW0;
         else if (sw_hit[1])            sel = RSEL_SW1;
         else if (sw_hit[2])            sel = RSEL_SW2;
      end
   end

   always_comb begin
      unique case (sel)
         RSEL_KEY: rd_data = {strobe_q, code_q};
         RSEL_ANY: rd_data = {any_down, {CODE_W{1'b0}}};
         RSEL_SW0: rd_data = {gsw[0], {CODE_W{1'b0}}};
         RSEL_SW1: rd_data = {gsw[1], {CODE_W{1'b0}}};
         RSEL_SW2: rd_data = {gsw[2], {CODE_W{1'b0}}};
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/kbd_strobe_port.sv
module kbd_strobe_port #(
   parameter int                ADDR_W    = 16,
   parameter int                CODE_W    = 7,
   parameter int                NKEYS     = 64,
   parameter int                IDX_W     = $clog2(NKEYS),
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 16'hC000,
   parameter logic [ADDR_W-1:0] CLR_ADDR  = 16'hC010,
   parameter logic [ADDR_W-1:0] SW_BASE   = 16'hC061,
   parameter int                RST_IDX   = 63,
   parameter int                CTRL_IDX  = 62,
   parameter int                SHIFT_IDX = 61,
   parameter int                CAPS_IDX  = 60,
   parameter int                OPEN_IDX  = 59,
   parameter int                SOLID_IDX = 58
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_evt,
   input  logic [IDX_W-1:0]  key_idx,
   input  logic [CODE_W-1:0] key_code,
   input  logic [NKEYS-1:0]  key_map,
   input  logic              shift_jmp,
   input  logic              bus_sel,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [CODE_W:0]   rd_data,
   output logic [2:0]        game_sw,
   output logic              sys_rst_req
);
   localparam logic [NKEYS-1:0] ONE = NKEYS'(1);
   localparam logic [NKEYS-1:0] MOD_MASK =
      (ONE << RST_IDX) | (ONE << CTRL_IDX) | (ONE << SHIFT_IDX) |
      (ONE << CAPS_IDX) | (ONE << OPEN_IDX) | (ONE << SOLID_IDX);

   if ((1 << IDX_W) != NKEYS) begin : g_chk_keys
      $error("kbd_strobe_port: NKEYS must be a power of two matching IDX_W");
   end
   if ($countones(MOD_MASK) != 6) begin : g_chk_mods
      $error("kbd_strobe_port: modifier indices must be distinct");
   end

   logic              load;
   logic              clr_hit;
   logic              any_down;
   logic [CODE_W-1:0] code_q;
   logic              strobe_q;

   assign load = key_evt && !MOD_MASK[key_idx];

   kbd_latch #(.CODE_W(CODE_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .code_in  (key_code),
      .clr      (clr_hit),
      .code_q   (code_q),
      .strobe_q (strobe_q)
   );

   kbd_mod_route #(
      .NKEYS(NKEYS), .RST_IDX(RST_IDX), .CTRL_IDX(CTRL_IDX),
      .SHIFT_IDX(SHIFT_IDX), .OPEN_IDX(OPEN_IDX), .SOLID_IDX(SOLID_IDX),
      .MOD_MASK(MOD_MASK)
   ) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_map   (key_map),
      .shift_jmp (shift_jmp),
      .any_down  (any_down),
      .gsw       (game_sw),
      .rst_req   (sys_rst_req)
   );

   kbd_rd_mux #(
      .ADDR_W(ADDR_W), .CODE_W(CODE_W), .KEY_ADDR(KEY_ADDR),
      .CLR_ADDR(CLR_ADDR), .SW_BASE(SW_BASE)
   ) u_rd (
      .bus_sel  (bus_sel),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .code_q   (code_q),
      .strobe_q (strobe_q),
      .any_down (any_down),
      .gsw      (game_sw),
      .rd_data  (rd_data),
      .clr_hit  (clr_hit)
   );

   // R6: a modifier event leaves the strobe as it was or clears it
   a_r6_mod_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (key_evt && MOD_MASK[key_idx] && !strobe_q) |=> !strobe_q);
   // R11: idle bus reads as zero
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> (rd_data == '0));
endmodule

// File: tb/kbd_strobe_port_tb.sv
module kbd_strobe_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        key_evt = 1'b0;
   logic [5:0]  key_idx = '0;
   logic [6:0]  key_code = '0;
   logic [63:0] key_map = '0;
   logic        shift_jmp = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  rd_data;
   logic [2:0]  game_sw;
   logic        sys_rst_req;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [15:0] A_KEY = 16'hC000;
   localparam logic [15:0] A_CLR = 16'hC010;
   localparam logic [15:0] A_SW0 = 16'hC061;
   localparam int I_RST = 63, I_CTRL = 62, I_SHIFT = 61, I_CAPS = 60;
   localparam int I_OPEN = 59, I_SOLID = 58;

   always #2 clk = ~clk;

   kbd_strobe_port u_dut (
      .clk(clk), .rst_n(rst_n), .key_evt(key_evt), .key_idx(key_idx),
      .key_code(key_code), .key_map(key_map), .shift_jmp(shift_jmp),
      .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .rd_data(rd_data), .game_sw(game_sw), .sys_rst_req(sys_rst_req)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   task automatic press(int idx, logic [6:0] code);
      @(negedge clk);
      key_evt = 1'b1; key_idx = 6'(idx); key_code = code;
      @(negedge clk);
      key_evt = 1'b0;
   endtask

   task automatic rd(logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
      #1 d = rd_data;
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic wr(logic [15:0] a);
      @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(A_KEY, d);
      chk("R1 key read after reset", d, 8'h00);
      chk("R1 game_sw after reset", game_sw, 3'b000);
      chk("R1 reset request after reset", sys_rst_req, 1'b0);
   endtask

   task automatic t_latch();
      logic [7:0] d;
      press(5, 7'h41);
      rd(A_KEY, d);
      chk("R2 R3 first key", d, 8'hC1);
      rd(A_KEY, d);
      chk("R3 key read keeps strobe", d, 8'hC1);
      press(6, 7'h42);
      rd(A_KEY, d);
      chk("R2 overwrite without ack", d, 8'hC2);
   endtask

   task automatic t_clear();
      logic [7:0] d;
      key_map = 64'h40;
      rd(A_CLR, d);
      chk("R5 ack read any-key-down", d, 8'h80);
      rd(A_KEY, d);
      chk("R4 strobe cleared by read", d, 8'h42);
      press(7, 7'h33);
      wr(A_CLR);
      rd(A_KEY, d);
      chk("R4 strobe cleared by write", d, 8'h33);
      key_map = '0;
   endtask

   task automatic t_anykey();
      logic [7:0] d;
      key_map = '0;
      key_map[I_RST] = 1; key_map[I_CTRL] = 1; key_map[I_SHIFT] = 1;
      key_map[I_CAPS] = 1; key_map[I_OPEN] = 1; key_map[I_SOLID] = 1;
      rd(A_CLR, d);
      chk("R5 modifiers only not down", d, 8'h00);
      key_map[57] = 1'b1;
      rd(A_CLR, d);
      chk("R5 index 57 counts", d, 8'h80);
      key_map = 64'h1;
      rd(A_CLR, d);
      chk("R5 index 0 counts", d, 8'h80);
      key_map = '0;
      rd(A_CLR, d);
      chk("R5 nothing held", d, 8'h00);
   endtask

   task automatic t_mod_event();
      logic [7:0] d;
      press(I_SHIFT, 7'h7F);
      rd(A_KEY, d);
      chk("R6 shift event ignored", d, 8'h33);
      press(I_CAPS, 7'h11);
      press(I_RST, 7'h12);
      rd(A_KEY, d);
      chk("R6 caps and reset events ignored", d, 8'h33);
   endtask

   task automatic t_collision();
      logic [7:0] d;
      @(negedge clk);
      key_evt = 1'b1; key_idx = 6'd9; key_code = 7'h55;
      bus_sel = 1'b1; bus_rd = 1'b0; bus_addr = A_CLR;
      @(negedge clk);
      key_evt = 1'b0; bus_sel = 1'b0;
      rd(A_KEY, d);
      chk("R7 event wins over ack", d, 8'hD5);
   endtask

   task automatic t_switches();
      logic [7:0] d;
      key_map = '0; key_map[I_OPEN] = 1'b1;
      settle();
      chk("R8 open key to switch 0", game_sw, 3'b001);
      rd(A_SW0, d);
      chk("R8 switch 0 readback", d, 8'h80);
      rd(A_SW0 + 16'd1, d);
      chk("R8 switch 1 idle readback", d, 8'h00);
      key_map = '0; key_map[I_SOLID] = 1'b1;
      settle();
      chk("R8 solid key to switch 1", game_sw, 3'b010);
      rd(A_SW0 + 16'd1, d);
      chk("R8 switch 1 readback", d, 8'h80);
      key_map = '0;
   endtask

   task automatic t_jumper();
      logic [7:0] d;
      shift_jmp = 1'b0;
      key_map = '0; key_map[I_SHIFT] = 1'b1;
      settle();
      chk("R9 shift with jumper off", game_sw, 3'b000);
      rd(A_SW0 + 16'd2, d);
      chk("R9 switch 2 readback jumper off", d, 8'h00);
      shift_jmp = 1'b1;
      settle();
      chk("R9 shift with jumper on", game_sw, 3'b100);
      rd(A_SW0 + 16'd2, d);
      chk("R9 switch 2 readback jumper on", d, 8'h80);
      shift_jmp = 1'b0; key_map = '0;
   endtask

   task automatic t_reset_combo();
      key_map = '0; key_map[I_RST] = 1'b1;
      settle();
      chk("R10 reset alone", sys_rst_req, 1'b0);
      key_map[I_CTRL] = 1'b1;
      settle();
      chk("R10 control plus reset", sys_rst_req, 1'b1);
      key_map[I_RST] = 1'b0;
      settle();
      chk("R10 control alone", sys_rst_req, 1'b0);
      key_map = '0;
   endtask

   task automatic t_other();
      logic [7:0] d;
      press(3, 7'h21);
      rd(16'hC020, d);
      chk("R11 unmapped address", d, 8'h00);
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b1; bus_addr = A_KEY;
      #1 chk("R11 no select", rd_data, 8'h00);
      bus_rd = 1'b0;
      rd(A_KEY, d);
      chk("R11 strobe kept after other reads", d, 8'hA1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latch();
      t_clear();
      t_anykey();
      t_mod_event();
      t_collision();
      t_switches();
      t_jumper();
      t_reset_combo();
      t_other();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule